// File: doc/BRIEF.md
# Holdover Frequency History Averager

While a timing loop is locked, this block records the frequency-control word it is handed on every sample tick. The records go into a circular store of parameterised depth. When the loop falls into holdover, one strobe tells the block to average a window of past records. That average becomes the word the oscillator is held at. The block also reports whether enough history existed to trust the result.

Two codes shape the averaged span, and both are powers of two of a base tick. Here one tick is one accepted sample. The window code selects (2^code − 1) samples. The delay code selects 2^code of the newest samples, which are skipped because they may already be disturbed by the failing input. Both spans are limited to half the store. Recording only happens while the accumulate-enable input is high. When that input drops, recording pauses and keeps the samples already stored, then resumes when it rises again.

A four-state machine does the work:
- IDLE waits for the holdover strobe, and on that strobe takes the INVALID path or the START path.
- SUM adds the window samples one per cycle, oldest-last, walking backward from just before the excluded span.
- DIV runs a serial restoring divide by the window length.
- FIN presents the result for one cycle and returns to IDLE.

The transitions are named as follows:
- IDLE→SUM (START) when the history is sufficient.
- IDLE→FIN (INVALID) when it is not.
- SUM→DIV (SUMMED) once the window count is exhausted.
- DIV→FIN (QUOTIENT) when the divider finishes.
- FIN→IDLE (PRESENT), which happens unconditionally.

Top module: `hold_avg_top`

## Requirements
- R1: After reset the store and sample count are empty, and `avg_out`, `hist_ok` and `avg_done` are 0, so a holdover strobe issued straight after reset reports `hist_ok`=0.
- R2: A sample is recorded only on a cycle with `smp_stb`=1 and `acc_en`=1. Strobes while `acc_en`=0 are ignored, and the samples already held are kept, not cleared.
- R3: The sample count saturates at DEPTH. Later samples overwrite the oldest, so the average is always taken over the most recent records.
- R4: The window length is 2^`len_code` − 1 samples. `len_code`=0 is treated as 1 sample, and the length is limited to DEPTH/2.
- R5: The delay length is 2^`dly_code` samples, limited to DEPTH/2.
- R6: `avg_out` is the floor of the arithmetic mean of the window samples, which are the samples immediately older than the newest delay-length samples. Those newest samples are excluded.
- R7: `hist_ok` is 1 exactly when the count at the holdover strobe is at least window + delay. When it is 0, `avg_out` is 0.
- R8: `avg_done` is a single-cycle pulse marking new `avg_out`/`hist_ok` values. Those values hold until the next pulse.
- R9: If a sample strobe arrives in the same cycle as the holdover strobe, or while a computation is in progress, the sample is not recorded.
- R10: A holdover strobe during a computation in progress is ignored and produces no extra `avg_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample tick |
| freq_in | input | W | Frequency word to record |
| acc_en | input | 1 | Loop locked and input valid |
| len_code | input | 5 | Window length code |
| dly_code | input | 5 | Excluded delay code |
| hold_stb | input | 1 | Holdover entry strobe |
| avg_out | output | W | Averaged frequency word |
| hist_ok | output | 1 | History was sufficient |
| avg_done | output | 1 | Result-ready pulse |

## Verification
The collision of interest is a sample tick landing in the same cycle as the holdover strobe. A tick landing while the machine is still summing or dividing is the same kind of collision. The bench drives an out-of-range sample value together with the holdover strobe. It then fires a second holdover strobe and another sample mid-computation. It judges the outcome in two ways. First, the average must equal the mean of the window computed without that sample. Second, a repeated holdover afterwards must return the identical result, and exactly one done pulse may appear per accepted strobe.

// File: rtl/hold_avg_pkg.sv
package hold_avg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUM  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIN  = 2'd3
    } hx_state_t;
endpackage

// File: rtl/hist_ring.sv
module hist_ring #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic [AW-1:0] wr_ptr,
    output logic [CW-1:0] count
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            wr_ptr      <= wr_ptr + AW'(1);
            if (count != CW'(DEPTH)) count <= count + CW'(1);
        end
    end

    assign rd_data = mem[rd_idx];

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_PAUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(count) && $stable(wr_ptr))); // R2
endmodule

// File: rtl/span_decode.sv
module span_decode #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic [4:0]    len_code,
    input  logic [4:0]    dly_code,
    output logic [CW-1:0] win_len,
    output logic [CW-1:0] dly_len
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        if (int'(len_code) >= AW)      win_len = CW'(HALF);
        else if (len_code == 5'd0)     win_len = ONE;
        else                           win_len = (ONE << len_code) - ONE;

        if (int'(dly_code) >= AW - 1)  dly_len = CW'(HALF);
        else                           dly_len = ONE << dly_code;
    end
endmodule

// File: rtl/serial_div.sv
module serial_div #(
    parameter int SW = 22,
    parameter int CW = 7,
    parameter int W  = 16,
    localparam int NW = $clog2(SW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] dividend,
    input  logic [CW-1:0] divisor,
    output logic [SW-1:0] quotient,
    output logic          done
);
    logic [CW:0]   rem;
    logic [CW:0]   sh;
    logic [CW-1:0] dvsr;
    logic [NW-1:0] steps;
    logic          busy;

    assign sh = {rem[CW-1:0], quotient[SW-1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            quotient <= '0;
            dvsr     <= '0;
            steps    <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quotient <= dividend;
                rem      <= '0;
                dvsr     <= divisor;
                steps    <= NW'(SW);
                busy     <= 1'b1;
            end else if (busy) begin
                if (sh >= {1'b0, dvsr}) begin
                    rem      <= sh - {1'b0, dvsr};
                    quotient <= {quotient[SW-2:0], 1'b1};
                end else begin
                    rem      <= sh;
                    quotient <= {quotient[SW-2:0], 1'b0};
                end
                steps <= steps - NW'(1);
                if (steps == NW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_QUO_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quotient[SW-1:W] == '0)); // R6
endmodule

// File: rtl/hold_avg_top.sv
module hold_avg_top
    import hold_avg_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int SW   = W + AW,
    localparam int HALF = DEPTH / 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_stb,
    input  logic [W-1:0] freq_in,
    input  logic         acc_en,
    input  logic [4:0]   len_code,
    input  logic [4:0]   dly_code,
    input  logic         hold_stb,
    output logic [W-1:0] avg_out,
    output logic         hist_ok,
    output logic         avg_done
);
    hx_state_t     state, nxt;
    logic          wr_en;
    logic [W-1:0]  rd_data;
    logic [AW-1:0] wr_ptr, rd_idx;
    logic [CW-1:0] count;
    logic [CW-1:0] win_len, dly_len, win_lat, left;
    logic [SW-1:0] acc, quo;
    logic          div_start, div_done, ok_lat, enough;
    logic [W-1:0]  res;

    assign wr_en     = smp_stb && acc_en && !hold_stb && (state == ST_IDLE);
    assign enough    = {1'b0, count} >= ({1'b0, win_len} + {1'b0, dly_len});
    assign div_start = (state == ST_SUM) && (left == '0);

    hist_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (freq_in),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_ptr  (wr_ptr),
        .count   (count)
    );

    span_decode #(.DEPTH(DEPTH)) u_span (
        .len_code (len_code),
        .dly_code (dly_code),
        .win_len  (win_len),
        .dly_len  (dly_len)
    );

    serial_div #(.SW(SW), .CW(CW), .W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (acc),
        .divisor  (win_lat),
        .quotient (quo),
        .done     (div_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: START, INVALID, SUMMED, QUOTIENT, PRESENT
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (hold_stb) nxt = enough ? ST_SUM : ST_FIN;
            ST_SUM:  if (left == '0) nxt = ST_DIV;
            ST_DIV:  if (div_done) nxt = ST_FIN;
            ST_FIN:  nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx  <= '0;
            left    <= '0;
            win_lat <= CW'(1);
            acc     <= '0;
            ok_lat  <= 1'b0;
            res     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (hold_stb) begin
                    ok_lat  <= enough;
                    win_lat <= win_len;
                    left    <= win_len;
                    acc     <= '0;
                    res     <= '0;
                    rd_idx  <= wr_ptr - AW'(1) - dly_len[AW-1:0];
                end
                ST_SUM: if (left != '0) begin
                    acc    <= acc + SW'(rd_data);
                    rd_idx <= rd_idx - AW'(1);
                    left   <= left - CW'(1);
                end
                ST_DIV: if (div_done) res <= quo[W-1:0];
                ST_FIN: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_out  <= '0;
            hist_ok  <= 1'b0;
            avg_done <= 1'b0;
        end else begin
            avg_done <= (state == ST_FIN);
            if (state == ST_FIN) begin
                avg_out <= res;
                hist_ok <= ok_lat;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        avg_done |=> !avg_done); // R8
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_done && !hist_ok) |-> (avg_out == '0)); // R7
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(count)); // R9
    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_len >= CW'(1)) && (win_len <= CW'(HALF)) && (dly_len <= CW'(HALF))); // R4
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUM) |=> (state != ST_IDLE)); // R10
endmodule

// File: tb/tb_hold_avg_top.sv
module tb_hold_avg_top;
    localparam int W = 16;
    localparam int DEPTH = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic smp_stb = 1'b0, acc_en = 1'b0, hold_stb = 1'b0;
    logic [W-1:0] freq_in = '0;
    logic [4:0] len_code = '0, dly_code = '0;
    logic [W-1:0] avg_out;
    logic hist_ok, avg_done;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] mh [0:1023];
    int nm = 0;
    int gk = 0;

    always #2 clk = ~clk;

    hold_avg_top #(.W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .freq_in(freq_in),
        .acc_en(acc_en), .len_code(len_code), .dly_code(dly_code),
        .hold_stb(hold_stb), .avg_out(avg_out), .hist_ok(hist_ok),
        .avg_done(avg_done)
    );

    typedef struct packed {
        logic [4:0] len;
        logic [4:0] dly;
        logic [7:0] n;
        logic       ok;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{len: 5'd2,  dly: 5'd0,  n: 8'd4,   ok: 1'b1},
        '{len: 5'd2,  dly: 5'd0,  n: 8'd3,   ok: 1'b0},
        '{len: 5'd3,  dly: 5'd2,  n: 8'd20,  ok: 1'b1},
        '{len: 5'd0,  dly: 5'd1,  n: 8'd3,   ok: 1'b1},
        '{len: 5'd31, dly: 5'd31, n: 8'd64,  ok: 1'b1},
        '{len: 5'd5,  dly: 5'd5,  n: 8'd100, ok: 1'b1},
        '{len: 5'd6,  dly: 5'd0,  n: 8'd32,  ok: 1'b0},
        '{len: 5'd4,  dly: 5'd3,  n: 8'd23,  ok: 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int win_of(input int c);
        int v;
        v = (c >= 6) ? DEPTH / 2 : ((1 << c) - 1);
        if (v < 1) v = 1;
        if (v > DEPTH / 2) v = DEPTH / 2;
        return v;
    endfunction

    function automatic int dly_of(input int c);
        int v;
        v = (c >= 6) ? DEPTH / 2 : (1 << c);
        if (v > DEPTH / 2) v = DEPTH / 2;
        return v;
    endfunction

    function automatic logic [W-1:0] exp_avg(input int w, input int d);
        longint s = 0;
        for (int j = 0; j < w; j++) s += mh[nm - 1 - d - j];
        return W'(s / w);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; smp_stb = 1'b0; hold_stb = 1'b0; acc_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nm = 0;
    endtask

    task automatic push(input logic [W-1:0] v);
        @(negedge clk); freq_in = v; smp_stb = 1'b1; acc_en = 1'b1;
        @(negedge clk); smp_stb = 1'b0;
        mh[nm] = v; nm++;
    endtask

    task automatic next_val(output logic [W-1:0] v);
        v = W'(16'hF000 + ((gk * 97) % 4096));
        gk++;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (avg_done) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic holdover(input logic [4:0] lc, input logic [4:0] dc, output bit got);
        @(negedge clk); len_code = lc; dly_code = dc; hold_stb = 1'b1;
        @(negedge clk); hold_stb = 1'b0;
        wait_done(got);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit got;
        logic [W-1:0] v, first;
        int w, d;

        // R1: reset state
        do_reset();
        chk("R1 avg_out", avg_out, 0);
        chk("R1 hist_ok", hist_ok, 0);
        chk("R1 avg_done", avg_done, 0);
        holdover(5'd0, 5'd0, got);
        chk("R1 done", got, 1);
        chk("R1 empty history", hist_ok, 0);

        // vector table: R3 R4 R5 R6 R7
        for (int k = 0; k < 8; k++) begin
            do_reset();
            for (int i = 0; i < int'(VECS[k].n); i++) begin
                next_val(v);
                push(v);
            end
            w = win_of(int'(VECS[k].len));
            d = dly_of(int'(VECS[k].dly));
            holdover(VECS[k].len, VECS[k].dly, got);
            chk("R8 done pulse", got, 1);
            chk("R7 hist_ok", hist_ok, VECS[k].ok);
            if (VECS[k].ok) chk("R6 R4 R5 R3 average", avg_out, exp_avg(w, d));
            else            chk("R7 zero when invalid", avg_out, 0);
            @(negedge clk);
            chk("R8 single pulse", avg_done, 0);
        end

        // R2: pause keeps history, gated strobes ignored
        do_reset();
        push(16'h0100); push(16'h0200); push(16'h0300);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); freq_in = 16'hEEEE; smp_stb = 1'b1; acc_en = 1'b0;
        end
        @(negedge clk); smp_stb = 1'b0;
        push(16'h0400);
        holdover(5'd2, 5'd0, got);
        chk("R2 valid after pause", hist_ok, 1);
        chk("R2 paused average", avg_out, 16'h0200);

        // R9 R10: sample with holdover strobe and during busy
        do_reset();
        push(16'h0010); push(16'h0020); push(16'h0060); push(16'h0070);
        @(negedge clk);
        len_code = 5'd2; dly_code = 5'd0;
        hold_stb = 1'b1; smp_stb = 1'b1; acc_en = 1'b1; freq_in = 16'hFFFF;
        @(negedge clk);
        hold_stb = 1'b1; smp_stb = 1'b1; freq_in = 16'hFFFF;
        @(negedge clk);
        hold_stb = 1'b0; smp_stb = 1'b0;
        wait_done(got);
        chk("R9 done", got, 1);
        chk("R9 colliding sample dropped", avg_out, exp_avg(3, 1));
        first = avg_out;
        got = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (avg_done) got = 1'b1;
        end
        chk("R10 no extra done", got, 0);
        chk("R8 result held", avg_out, first);
        holdover(5'd2, 5'd0, got);
        chk("R9 busy sample dropped", avg_out, first);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule